// File: doc/BRIEF.md
# Duplex Lockstep Node Matcher

This block watches two copies of a processor that run in lockstep from one clock. Each copy brings out a bank of internal observation nodes, all packed into one flat vector. In every machine cycle that the cycle strobe marks, the matcher compares a small subset of those nodes, bit for bit, between the two copies. The subset depends on the class of the instruction that is executing, so the nodes that instruction actually exercises are the ones that get compared. Both copies share a clock, so the values are compared in the cycle they appear and nothing is buffered to remove skew.

A disagreement produces a one-cycle mismatch pulse, which marks the failing cycle. It also sets a sticky error flag, and the index of the lowest-numbered failing node of that first disagreement is stored. The flag and the index hold until reset. By default there are 16 nodes of 24 bits and two are compared per cycle. A smaller configuration with six nodes and one compare per cycle is selected by parameters. The block does not decide which copy is faulty and does not reconfigure anything.

Top module: `dlm_top`

## Requirements
- R1: After reset, `mismatch`, `err_sticky` and `fail_node` are all zero.
- R2: For instruction class c, compare slot k examines node (c + k*(NODES/PICKS)) mod NODES. With the defaults these are nodes c and (c+8) mod 16. A difference in any node that is not selected raises no mismatch.
- R3: When `cyc_stb` is high and any bit differs between the copies in a selected node, `mismatch` is 1 for exactly the next cycle. A single flipped bit, including the top bit of a node, is enough.
- R4: When `cyc_stb` is low, no comparison happens. `mismatch` is 0 in the next cycle and the error state does not change, whatever the banks hold.
- R5: `err_sticky` rises together with the first `mismatch` pulse and stays 1 until reset.
- R6: With the first mismatch, `fail_node` takes the lowest-numbered failing node among the selected ones, whatever the slot order. Later mismatches leave it unchanged until reset.
- R7: Equal banks under a high strobe never raise `mismatch`, for any class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common lockstep clock |
| rst | input | 1 | Synchronous active-high reset; also clears the error state |
| cyc_stb | input | 1 | Marks a machine cycle whose nodes are compared |
| iclass | input | CLASS_W (4) | Instruction class that steers node selection |
| bank_a | input | NODES*NODE_W (384) | Observation nodes of copy A, node n at bits n*NODE_W upward |
| bank_b | input | NODES*NODE_W (384) | Observation nodes of copy B, same layout |
| mismatch | output | 1 | One-cycle pulse that follows a failing compare |
| err_sticky | output | 1 | Set by the first mismatch, held until reset |
| fail_node | output | clog2(NODES) (4) | Lowest failing node index of the first mismatch |

## Verification
Every result is registered once. Inputs applied before clock edge N show on `mismatch`, `err_sticky` and `fail_node` after edge N, and stay there until edge N+1. The bench drives inputs on the falling edge and samples on the next falling edge, after exactly one rising edge, so each check sees the result of the stimulus just applied. The cases where a stimulus must have no effect (an unselected node, a low strobe, a second failure) are checked in that same following cycle, before new inputs arrive.

// File: rtl/dlm_pkg.sv
package dlm_pkg;

    localparam int unsigned DLM_NODES_DEF  = 16;
    localparam int unsigned DLM_NODE_W_DEF = 24;
    localparam int unsigned DLM_PICKS_DEF  = 2;
    localparam int unsigned DLM_CLASS_W    = 4;

    // Node examined by compare slot k for a given instruction class.
    // The slots are spread evenly around the bank, so they never coincide.
    function automatic int unsigned pick_node(
        input int unsigned cls,
        input int unsigned k,
        input int unsigned nodes,
        input int unsigned picks
    );
        return (cls + k * (nodes / picks)) % nodes;
    endfunction

    // Result of one compare cycle
    typedef enum logic [1:0] {
        VERD_IDLE  = 2'd0,
        VERD_MATCH = 2'd1,
        VERD_FAIL  = 2'd2
    } verdict_e;

endpackage

// File: rtl/dlm_selector.sv
module dlm_selector
    import dlm_pkg::*;
#(
    parameter int unsigned NODES   = DLM_NODES_DEF,
    parameter int unsigned PICKS   = DLM_PICKS_DEF,
    parameter int unsigned CLASS_W = DLM_CLASS_W,
    localparam int unsigned IDX_W  = $clog2(NODES)
) (
    input  logic [CLASS_W-1:0]          iclass,
    output logic [PICKS-1:0][IDX_W-1:0] sel
);

    for (genvar k = 0; k < PICKS; k++) begin : g_slot
        assign sel[k] = IDX_W'(pick_node(int'(iclass), k, NODES, PICKS));
    end

endmodule

// File: rtl/dlm_compare.sv
module dlm_compare
    import dlm_pkg::*;
#(
    parameter int unsigned NODES  = DLM_NODES_DEF,
    parameter int unsigned NODE_W = DLM_NODE_W_DEF,
    parameter int unsigned PICKS  = DLM_PICKS_DEF,
    localparam int unsigned IDX_W = $clog2(NODES),
    localparam int unsigned BANK_W = NODES * NODE_W
) (
    input  logic [BANK_W-1:0]           bank_a,
    input  logic [BANK_W-1:0]           bank_b,
    input  logic [PICKS-1:0][IDX_W-1:0] sel,
    output logic                        any_diff,
    output logic [IDX_W-1:0]            low_idx
);

    logic [PICKS-1:0] diff;

    for (genvar k = 0; k < PICKS; k++) begin : g_cmp
        logic [NODE_W-1:0] node_a;
        logic [NODE_W-1:0] node_b;
        assign node_a  = bank_a[int'(sel[k]) * NODE_W +: NODE_W];
        assign node_b  = bank_b[int'(sel[k]) * NODE_W +: NODE_W];
        assign diff[k] = |(node_a ^ node_b);
    end

    // Pick the smallest node index among the failing slots
    always_comb begin
        any_diff = 1'b0;
        low_idx  = '0;
        for (int k = 0; k < PICKS; k++) begin
            if (diff[k] && (!any_diff || sel[k] < low_idx)) begin
                low_idx  = sel[k];
                any_diff = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dlm_status.sv
module dlm_status
    import dlm_pkg::*;
#(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  verdict_e         verdict,
    input  logic [IDX_W-1:0] low_idx,
    output logic             mismatch,
    output logic             err_sticky,
    output logic [IDX_W-1:0] fail_node
);

    always_ff @(posedge clk) begin
        if (rst) begin
            mismatch   <= 1'b0;
            err_sticky <= 1'b0;
            fail_node  <= '0;
        end else begin
            mismatch <= (verdict == VERD_FAIL);
            if (verdict == VERD_FAIL && !err_sticky) begin
                err_sticky <= 1'b1;
                fail_node  <= low_idx;
            end
        end
    end

endmodule

// File: rtl/dlm_top.sv
module dlm_top
    import dlm_pkg::*;
#(
    parameter int unsigned NODES   = DLM_NODES_DEF,
    parameter int unsigned NODE_W  = DLM_NODE_W_DEF,
    parameter int unsigned PICKS   = DLM_PICKS_DEF,
    parameter int unsigned CLASS_W = DLM_CLASS_W,
    localparam int unsigned IDX_W  = $clog2(NODES),
    localparam int unsigned BANK_W = NODES * NODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cyc_stb,
    input  logic [CLASS_W-1:0] iclass,
    input  logic [BANK_W-1:0]  bank_a,
    input  logic [BANK_W-1:0]  bank_b,
    output logic               mismatch,
    output logic               err_sticky,
    output logic [IDX_W-1:0]   fail_node
);

    logic [PICKS-1:0][IDX_W-1:0] sel;
    logic                        any_diff;
    logic [IDX_W-1:0]            low_idx;
    verdict_e                    verdict;

    dlm_selector #(
        .NODES(NODES), .PICKS(PICKS), .CLASS_W(CLASS_W)
    ) u_sel (
        .iclass(iclass),
        .sel   (sel)
    );

    dlm_compare #(
        .NODES(NODES), .NODE_W(NODE_W), .PICKS(PICKS)
    ) u_cmp (
        .bank_a  (bank_a),
        .bank_b  (bank_b),
        .sel     (sel),
        .any_diff(any_diff),
        .low_idx (low_idx)
    );

    always_comb begin
        if (!cyc_stb)      verdict = VERD_IDLE;
        else if (any_diff) verdict = VERD_FAIL;
        else               verdict = VERD_MATCH;
    end

    dlm_status #(.IDX_W(IDX_W)) u_stat (
        .clk       (clk),
        .rst       (rst),
        .verdict   (verdict),
        .low_idx   (low_idx),
        .mismatch  (mismatch),
        .err_sticky(err_sticky),
        .fail_node (fail_node)
    );

endmodule

// File: rtl/dlm_checker.sv
module dlm_checker #(
    parameter int unsigned NODES = 16,
    localparam int unsigned IDX_W = $clog2(NODES)
) (
    input logic             clk,
    input logic             rst,
    input logic             cyc_stb,
    input logic             mismatch,
    input logic             err_sticky,
    input logic [IDX_W-1:0] fail_node
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!mismatch && !err_sticky && fail_node == '0));

    p_pulse_needs_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> $past(cyc_stb));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        !cyc_stb |=> !mismatch);

    p_flag_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        mismatch |-> err_sticky);

    p_flag_holds_r5: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> err_sticky);

    p_index_holds_r6: assert property (@(posedge clk) disable iff (rst)
        err_sticky |=> $stable(fail_node));

endmodule

bind dlm_top dlm_checker #(.NODES(NODES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cyc_stb   (cyc_stb),
    .mismatch  (mismatch),
    .err_sticky(err_sticky),
    .fail_node (fail_node)
);

// File: tb/tb_dlm_top.sv
`timescale 1ns/1ps
module tb_dlm_top;

    localparam int NODES  = 16;
    localparam int NODE_W = 24;
    localparam int BANK_W = NODES * NODE_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              cyc_stb;
    logic [3:0]        iclass;
    logic [BANK_W-1:0] bank_a;
    logic [BANK_W-1:0] bank_b;
    logic              mismatch;
    logic              err_sticky;
    logic [3:0]        fail_node;

    int n_run  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dlm_top dut (
        .clk(clk), .rst(rst), .cyc_stb(cyc_stb), .iclass(iclass),
        .bank_a(bank_a), .bank_b(bank_b),
        .mismatch(mismatch), .err_sticky(err_sticky), .fail_node(fail_node)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply inputs on the falling edge, let one rising edge pass, sample.
    task automatic step(input logic stb, input int cls);
        cyc_stb = stb;
        iclass  = 4'(cls);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic flip(input int node, input int bitpos);
        bank_b[node*NODE_W + bitpos] = ~bank_b[node*NODE_W + bitpos];
    endtask

    task automatic do_reset();
        rst = 1'b1; cyc_stb = 1'b0; iclass = '0;
        for (int n = 0; n < NODES; n++) bank_a[n*NODE_W +: NODE_W] = 24'h5A0000 + 24'(n * 3);
        bank_b = bank_a;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 mismatch", int'(mismatch), 0);
        chk("R1 err_sticky", int'(err_sticky), 0);
        chk("R1 fail_node", int'(fail_node), 0);
    endtask

    task automatic t_equal();
        for (int c = 0; c < 16; c++) begin
            step(1'b1, c);
            chk($sformatf("R7 equal class %0d", c), int'(mismatch), 0);
        end
        chk("R7 no error", int'(err_sticky), 0);
    endtask

    task automatic t_unselected();
        flip(5, 7);          // class 3 looks at nodes 3 and 11 only
        step(1'b1, 3);
        chk("R2 unselected node ignored", int'(mismatch), 0);
        chk("R2 no error", int'(err_sticky), 0);
        flip(5, 7);
    endtask

    task automatic t_idle();
        flip(10, 0);         // class 2 would select node 10
        step(1'b0, 2);
        chk("R4 strobe low no pulse", int'(mismatch), 0);
        chk("R4 strobe low no error", int'(err_sticky), 0);
        flip(10, 0);
    endtask

    task automatic t_single_bit();
        flip(10, 23);        // top bit of node 10, second slot of class 2
        step(1'b1, 2);
        chk("R3 pulse after top bit flip", int'(mismatch), 1);
        chk("R5 error set with pulse", int'(err_sticky), 1);
        chk("R6 index of node 10", int'(fail_node), 10);
        step(1'b0, 2);
        chk("R3 pulse lasts one cycle", int'(mismatch), 0);
        chk("R5 error held", int'(err_sticky), 1);
        flip(10, 23);
        step(1'b1, 2);
        chk("R3 no pulse once equal", int'(mismatch), 0);
        chk("R5 error still held", int'(err_sticky), 1);
    endtask

    task automatic t_lowest();
        do_reset();
        flip(5, 1); flip(13, 2);   // class 5 selects 5 and 13
        step(1'b1, 5);
        chk("R6 lowest of two", int'(fail_node), 5);
        flip(5, 1); flip(13, 2);
        flip(4, 9);                // class 12 selects 12 and 4
        step(1'b1, 12);
        chk("R3 later pulse", int'(mismatch), 1);
        chk("R6 first index kept", int'(fail_node), 5);
        flip(4, 9);
    endtask

    task automatic t_wrap();
        do_reset();
        flip(9, 4); flip(1, 4);    // class 9 selects 9 and (9+8) mod 16 = 1
        step(1'b1, 9);
        chk("R2 wrapped slot compared", int'(mismatch), 1);
        chk("R6 lower second slot wins", int'(fail_node), 1);
        flip(9, 4); flip(1, 4);
        do_reset();
        flip(15, 12);              // class 7 selects 7 and 15
        step(1'b1, 7);
        chk("R2 second slot node 15", int'(fail_node), 15);
        rst = 1'b1;
        step(1'b0, 0);
        rst = 1'b0;
        chk("R5 cleared by reset", int'(err_sticky), 0);
        flip(15, 12);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog R1..: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        bank_a = '0; bank_b = '0;
        @(negedge clk);
        t_reset();
        t_equal();
        t_unselected();
        t_idle();
        t_single_bit();
        t_lowest();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule